// File: doc/BRIEF.md
# CPU Program Bank Mapper

This block sits between a CPU address bus and external program memory. It translates each CPU access in the range 0x6000 to 0xFFFF into a physical memory address and chooses between program ROM and work RAM. The upper 32 KB of CPU space can be banked as one 32 KB window, as two 16 KB windows, as one 16 KB window plus two 8 KB windows, or as four 8 KB windows. The choice depends on a 2-bit mode register. The 8 KB window at 0x6000 always maps to work RAM, through its own 3-bit bank register.

Each 8-bit program bank value carries a ROM/RAM flag in its top bit. The other bits give the 8 KB page number. The bank serving the top window always reads as ROM, whatever value the CPU writes to it. RAM writes are enabled only while two protect key registers hold an unlock pattern. The CPU programs all registers with ordinary writes in the 0x51xx page. The block drives address and select lines only, and all outputs are registered one cycle after the access.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, the mode is 8 KB (3), bank registers 0 to 2 hold 0x00, bank register 3 holds 0xFF, both keys hold 0 and the RAM bank holds 0. An access to 0xE000 therefore maps to ROM page 0x7F.
- R2: An access to 0x6000 to 0x7FFF selects RAM at page {sel, bank}. The value sel is bit 2 and bank is bits 1:0 of the value written to 0x5113, and the offset is CPU address bits 12:0.
- R3: In mode 0, 0x8000 to 0xFFFF uses bank register 3 with its two low bits replaced by CPU address bits 14:13.
- R4: In mode 1, 0x8000 to 0xBFFF uses bank register 1 and 0xC000 to 0xFFFF uses bank register 3. In both cases bit 0 of the bank is replaced by CPU address bit 13.
- R5: In mode 2, 0x8000 to 0xBFFF uses bank register 1 with bit 0 replaced by address bit 13, 0xC000 to 0xDFFF uses bank register 2, and 0xE000 to 0xFFFF uses bank register 3.
- R6: In mode 3, the 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000 use bank registers 0, 1, 2 and 3 respectively.
- R7: For a program window, bit 7 of the chosen bank value set selects ROM and clear selects RAM. The physical address is {bank[6:0] (after substitution), address[12:0]}.
- R8: Any write to bank register 3 (0x5117) stores the value with bit 7 forced to 1, so 0xE000 to 0xFFFF always selects ROM.
- R9: The RAM write enable asserts only for a write to a RAM-mapped location while key 0 (0x5102, low 2 bits kept) equals 2 and key 1 (0x5103, low 2 bits kept) equals 1.
- R10: A write to a ROM-mapped location never asserts the RAM write enable.
- R11: An access below 0x6000, or a cycle with no request, drives map_valid, rom_sel, ram_sel and ram_we low. Register writes decode at 0x5100 (mode, bits 1:0), 0x5102, 0x5103, 0x5113 and 0x5114 to 0x5117 (bank registers 0 to 3).
- R12: Outputs are registered, so an access presented in one cycle appears on the outputs after the next rising clock edge. A register write takes effect for the access in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access valid this cycle |
| cpu_wr | input | 1 | Access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data (used for register writes) |
| map_valid | output | 1 | Registered: previous access hit 0x6000 to 0xFFFF |
| rom_sel | output | 1 | Registered: access targets program ROM |
| ram_sel | output | 1 | Registered: access targets work RAM |
| ram_we | output | 1 | Registered: RAM write enable |
| phys_addr | output | 20 | Registered physical byte address |

## Verification
Directed cases cover the reset mapping, the forced ROM flag after bank register 3 is written with zero, key values whose upper bits are set but whose low bits still unlock, and ROM-targeted writes. A seeded random stream mixes register writes in all four modes with reads and writes across 0x4000 to 0xFFFF, and a bench model predicts every output. The random stream separates the window and bit-substitution rules of each mode, because bank values with odd low bits expose a missing substitution. It also separates RAM-flagged pages from ROM-flagged pages, and locked key states from unlocked ones.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int CPU_AW = 16;
  localparam int OFF_W  = 13;
  localparam int NBANK  = 4;

  typedef enum logic [1:0] {
    PM_32K = 2'd0,
    PM_16K = 2'd1,
    PM_MIX = 2'd2,
    PM_8K  = 2'd3
  } prg_mode_e;

  localparam logic [CPU_AW-1:0] REG_MODE  = 16'h5100;
  localparam logic [CPU_AW-1:0] REG_KEY0  = 16'h5102;
  localparam logic [CPU_AW-1:0] REG_KEY1  = 16'h5103;
  localparam logic [CPU_AW-1:0] REG_WRAM  = 16'h5113;
  localparam logic [CPU_AW-1:0] REG_BANK0 = 16'h5114;
endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int KEY_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output prg_mode_e         mode_q,
  output logic [KEY_W-1:0]  key0_q,
  output logic [KEY_W-1:0]  key1_q,
  output logic [2:0]        wram_q,
  output logic [BANK_W-1:0] bank_q [NBANK]
);
  localparam logic [BANK_W-1:0] ROM_FLAG = BANK_W'(1) << (BANK_W-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_8K;
      key0_q <= '0;
      key1_q <= '0;
      wram_q <= '0;
    end else if (wr_stb) begin
      if (wr_addr == REG_MODE) mode_q <= prg_mode_e'(wr_data[1:0]);
      if (wr_addr == REG_KEY0) key0_q <= wr_data[KEY_W-1:0];
      if (wr_addr == REG_KEY1) key1_q <= wr_data[KEY_W-1:0];
      if (wr_addr == REG_WRAM) wram_q <= wr_data[2:0];
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [CPU_AW-1:0] MY_ADDR = REG_BANK0 + CPU_AW'(g);
    localparam bit IS_TOP = (g == NBANK-1);
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[g] <= IS_TOP ? '1 : '0;
      end else if (wr_stb && wr_addr == MY_ADDR) begin
        bank_q[g] <= IS_TOP ? (BANK_W'(wr_data) | ROM_FLAG) : BANK_W'(wr_data);
      end
    end
  end
endmodule

// File: rtl/prg_window_sel.sv
module prg_window_sel
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8,
  localparam int EW     = BANK_W - 1,
  localparam int PHYS_W = EW + OFF_W
) (
  input  logic [CPU_AW-1:0] addr,
  input  prg_mode_e         mode,
  input  logic [2:0]        wram,
  input  logic [BANK_W-1:0] bank [NBANK],
  output logic              in_range,
  output logic              is_rom,
  output logic [PHYS_W-1:0] phys
);
  logic [BANK_W-1:0] sel;
  logic [EW-1:0]     eff;

  always_comb begin
    in_range = addr[15] | (addr[15:13] == 3'b011);
    sel      = '0;
    eff      = '0;
    if (!addr[15]) begin
      eff = {{(EW-3){1'b0}}, wram};
    end else begin
      unique case (mode)
        PM_32K: begin
          sel = bank[3];
          eff = {sel[BANK_W-2:2], addr[14:13]};
        end
        PM_16K: begin
          sel = addr[14] ? bank[3] : bank[1];
          eff = {sel[BANK_W-2:1], addr[13]};
        end
        PM_MIX: begin
          if (!addr[14]) begin
            sel = bank[1];
            eff = {sel[BANK_W-2:1], addr[13]};
          end else begin
            sel = addr[13] ? bank[3] : bank[2];
            eff = sel[BANK_W-2:0];
          end
        end
        default: begin
          sel = bank[addr[14:13]];
          eff = sel[BANK_W-2:0];
        end
      endcase
    end
    is_rom = addr[15] & sel[BANK_W-1];
    phys   = {eff, addr[OFF_W-1:0]};
  end
endmodule

// File: rtl/prg_write_gate.sv
module prg_write_gate #(
  parameter int KEY_W = 2,
  parameter logic [KEY_W-1:0] UNLOCK0 = KEY_W'(2),
  parameter logic [KEY_W-1:0] UNLOCK1 = KEY_W'(1)
) (
  input  logic             req,
  input  logic             wr,
  input  logic             in_range,
  input  logic             is_rom,
  input  logic [KEY_W-1:0] key0,
  input  logic [KEY_W-1:0] key1,
  output logic             we
);
  logic unlocked;
  always_comb begin
    unlocked = (key0 == UNLOCK0) && (key1 == UNLOCK1);
    we = req & wr & in_range & ~is_rom & unlocked;
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int KEY_W  = 2,
  localparam int PHYS_W = BANK_W - 1 + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              map_valid,
  output logic              rom_sel,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [PHYS_W-1:0] phys_addr
);
  prg_mode_e         mode;
  logic [KEY_W-1:0]  key0, key1;
  logic [2:0]        wram;
  logic [BANK_W-1:0] bank [NBANK];
  logic              in_range, is_rom, we_c, reg_stb;
  logic [PHYS_W-1:0] phys_c;

  assign reg_stb = cpu_req & cpu_wr & (cpu_addr[15:13] < 3'b011);

  prg_map_regs #(.BANK_W(BANK_W), .KEY_W(KEY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(reg_stb), .wr_addr(cpu_addr),
    .wr_data(cpu_wdata), .mode_q(mode), .key0_q(key0), .key1_q(key1),
    .wram_q(wram), .bank_q(bank)
  );

  prg_window_sel #(.BANK_W(BANK_W)) u_sel (
    .addr(cpu_addr), .mode(mode), .wram(wram), .bank(bank),
    .in_range(in_range), .is_rom(is_rom), .phys(phys_c)
  );

  prg_write_gate #(.KEY_W(KEY_W)) u_gate (
    .req(cpu_req), .wr(cpu_wr), .in_range(in_range), .is_rom(is_rom),
    .key0(key0), .key1(key1), .we(we_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid <= 1'b0;
      rom_sel   <= 1'b0;
      ram_sel   <= 1'b0;
      ram_we    <= 1'b0;
      phys_addr <= '0;
    end else begin
      map_valid <= cpu_req & in_range;
      rom_sel   <= cpu_req & in_range & is_rom;
      ram_sel   <= cpu_req & in_range & ~is_rom;
      ram_we    <= we_c;
      phys_addr <= phys_c;
    end
  end
endmodule

module prg_bank_mapper_chk #(
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic [15:0]       cpu_addr,
  input logic              map_valid,
  input logic              rom_sel,
  input logic              ram_sel,
  input logic              ram_we,
  input logic [PHYS_W-1:0] phys_addr
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R7
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rom_sel && ram_sel));
  // R9
  we_needs_ram_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_sel);
  // R8
  top_is_rom_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cpu_req && cpu_addr[15:13] == 3'b111) |-> rom_sel);
  // R11
  below_range_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!cpu_req || cpu_addr[15:13] < 3'b011)
      |-> !map_valid && !rom_sel && !ram_sel && !ram_we);
  // R2
  wram_page_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(cpu_req && cpu_addr[15:13] == 3'b011)
      |-> ram_sel && phys_addr[PHYS_W-1:16] == '0);
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .map_valid(map_valid), .rom_sel(rom_sel), .ram_sel(ram_sel),
  .ram_we(ram_we), .phys_addr(phys_addr)
);

// File: tb/prg_bank_mapper_bench.sv
module prg_bank_mapper_bench;
  logic clk = 0, rst = 1, cpu_req = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic map_valid, rom_sel, ram_sel, ram_we;
  logic [19:0] phys_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prg_bank_mapper u_prg_bank_mapper (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .map_valid(map_valid),
    .rom_sel(rom_sel), .ram_sel(ram_sel), .ram_we(ram_we), .phys_addr(phys_addr)
  );

  // bench model state
  int m_mode, m_k0, m_k1, m_wram;
  int m_b[4];

  task automatic model_reset();
    m_mode = 3; m_k0 = 0; m_k1 = 0; m_wram = 0;
    m_b[0] = 0; m_b[1] = 0; m_b[2] = 0; m_b[3] = 255;
  endtask

  function automatic int pick_bank(int a);
    int w = (a >> 13) & 3;
    case (m_mode)
      0: return (m_b[3] & ~3) | w;
      1: return (a < 'hC000) ? ((m_b[1] & ~1) | (w & 1)) : ((m_b[3] & ~1) | (w & 1));
      2: if (a < 'hC000) return (m_b[1] & ~1) | (w & 1);
         else return (a < 'hE000) ? m_b[2] : m_b[3];
      default: return m_b[w];
    endcase
  endfunction

  function automatic string mode_tag(int a);
    if (a < 'h8000) return "R2";
    case (m_mode) 0: return "R3"; 1: return "R4"; 2: return "R5"; default: return "R6"; endcase
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, outputs checked at following negedge (R12)
  task automatic cycle(bit req, bit wr, int a, int d);
    bit   e_valid, e_rom, e_ram, e_we;
    int   e_phys, bk;
    string t;
    @(negedge clk);
    cpu_req = req; cpu_wr = wr; cpu_addr = 16'(a); cpu_wdata = 8'(d);
    e_valid = req && a >= 'h6000;
    bk = (a < 'h8000) ? m_wram : pick_bank(a);
    e_rom = e_valid && a >= 'h8000 && bk[7];
    e_ram = e_valid && !e_rom;
    e_we  = e_ram && wr && m_k0 == 2 && m_k1 == 1;
    e_phys = ((bk & 'h7f) << 13) | (a & 'h1fff);
    t = mode_tag(a);
    // model register update (R11 decode, R8 forced flag, R9 key width)
    if (req && wr && a < 'h6000) begin
      case (a)
        'h5100: m_mode = d & 3;
        'h5102: m_k0 = d & 3;
        'h5103: m_k1 = d & 3;
        'h5113: m_wram = d & 7;
        'h5114: m_b[0] = d & 255;
        'h5115: m_b[1] = d & 255;
        'h5116: m_b[2] = d & 255;
        'h5117: m_b[3] = (d & 255) | 'h80;
        default: ;
      endcase
    end
    @(negedge clk);
    chk(e_valid ? t : "R11", "map_valid", map_valid, e_valid);
    chk(e_valid ? "R7" : "R11", "rom_sel", rom_sel, e_rom);
    chk(e_valid ? "R7" : "R11", "ram_sel", ram_sel, e_ram);
    chk(e_rom ? "R10" : "R9", "ram_we", ram_we, e_we);
    if (e_valid) chk(t, "phys_addr", phys_addr, e_phys);
    cpu_req = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset outputs
    chk("R1", "map_valid", map_valid, 0);
    chk("R1", "ram_we", ram_we, 0);
    rst = 0;
    // R1: top window page 0x7F ROM
    cycle(1, 0, 'hE123, 0);
    chk("R1", "phys_addr", phys_addr, ('h7f << 13) | 'h0123);
    cycle(1, 0, 'h8004, 0);          // R6 bank0=0 -> RAM page 0
    // R8: write zero to bank 3, still ROM
    cycle(1, 1, 'h5117, 'h00);
    cycle(1, 0, 'hE000, 0);
    chk("R8", "rom_sel", rom_sel, 1);
    // R9: keys keep low 2 bits -> 6,5 unlock
    cycle(1, 1, 'h5102, 'h06);
    cycle(1, 1, 'h5103, 'h05);
    cycle(1, 1, 'h5113, 'h07);       // R2
    cycle(1, 1, 'h7FFF, 'h11);
    chk("R9", "ram_we", ram_we, 1);
    // R10: ROM write ignored
    cycle(1, 1, 'h5114, 'h85);
    cycle(1, 1, 'h8000, 'h22);
    chk("R10", "ram_we", ram_we, 0);
    // R11: below range and idle
    cycle(1, 0, 'h5000, 0);
    cycle(0, 1, 'h9000, 0);
    // R9: relock
    cycle(1, 1, 'h5103, 'h02);
    cycle(1, 1, 'h6000, 0);
    chk("R9", "ram_we", ram_we, 0);

    s = $urandom(1234);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 25) begin
        int offs[8] = '{'h5100, 'h5102, 'h5103, 'h5113, 'h5114, 'h5115, 'h5116, 'h5117};
        int a = offs[$urandom_range(0, 7)];
        int d = $urandom_range(0, 255);
        if ((a == 'h5102 || a == 'h5103) && $urandom_range(0, 1)) d = (a == 'h5102) ? 2 : 1;
        cycle(1, 1, a, d);
      end else begin
        cycle($urandom_range(0, 9) != 0, $urandom_range(0, 1), $urandom_range('h4000, 'hFFFF), $urandom_range(0, 255));
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule